// File: doc/BRIEF.md
# Calibrated Sensor Code Converter

This block turns a raw temperature-sensor ADC code into a signed temperature in milli-degrees Celsius. It applies one linear calibration shared by every sensor, plus a reference code for each sensor. Four kinds of calibration value live in a small register set, and all of them are loaded through a write-only configuration port:

- a 10-bit gain error,
- a 6-bit slope trim,
- a 6-bit reference temperature,
- one 9-bit reference code for each of the five sensors.

Each value comes out of reset with a fixed default.

The expensive part of the formula is a scale factor built from two truncating integer divisions. An iterative shift-subtract divider computes it whenever the calibration changes, so no divider macro is needed. While that runs, the block reports `busy`. Once the scale is ready, a request (a raw code plus a sensor index) costs one multiply, one arithmetic shift and two subtractions. The request is answered by a one-cycle `done` strobe with the result.

Sequencing is done by a four-state machine:

| State | Meaning |
|---|---|
| `ST_LOAD` | Arms the first division. |
| `ST_DIV_SLOPE` | Waits for the quotient by (165 + slope). |
| `ST_DIV_GAIN` | Waits for the quotient by (10000 + gain error). |
| `ST_READY` | Accepts requests. |

Its transitions are:

- Reset enters `ST_LOAD`.
- `ST_LOAD` goes to `ST_DIV_SLOPE` unconditionally.
- `ST_DIV_SLOPE` goes to `ST_DIV_GAIN` on the divider's done pulse, which also starts the second division.
- `ST_DIV_GAIN` goes to `ST_READY` on the done pulse, which stores the scale.
- A configuration write sends every state, including `ST_LOAD` itself, back to `ST_LOAD`.

Top module: `tsense_conv`

## Requirements
- R1: Only bits [11:0] of `req_raw` take part in a conversion; bits above them have no effect on `result`.
- R2: The scale is floor(floor(1627604160 / (165 + slope)) / (10000 + gain_error)), where 1627604160 is 203450520 shifted left by 3. Both divisions are unsigned and truncating.
- R3: `result` = ref_temp*500 - ((scale * (raw - ref_code[sensor] - 3350)) >>> 3). All steps use signed 32-bit two's-complement arithmetic and wrap on overflow.
- R4: After reset the gain error is 512, the slope is 0, the reference temperature is 40, and every sensor reference code is 260.
- R5: A write with `cfg_we` high uses `cfg_addr` to pick the register: 0 is the gain error (`cfg_wdata[9:0]`), 1 is the reference temperature (`cfg_wdata[5:0]`), 2 is the slope (`cfg_wdata[5:0]`), and 3+i is the reference code of sensor i (`cfg_wdata[8:0]`). Higher data bits are dropped.
- R6: `busy` is high during reset and is high in the cycle after any configuration write. It falls only when the two-stage recomputation has finished.
- R7: A request is accepted when `req_valid` is high, `busy` is low and `req_sensor` is below 5. `done` is then high for exactly the next cycle and `result` carries the value. When `done` is low, `result` holds its last value (0 after reset).
- R8: A request made while `busy` is high is ignored: it produces no `done` and does not change `result`.
- R9: A request with `req_sensor` of 5, 6 or 7 is ignored: it produces no `done` and does not change `result`.
- R10: When a configuration write and an accepted request share a cycle, the conversion uses the calibration as it stood before that write.
- R11: A configuration write during a recomputation restarts it. The scale that follows reflects every write made so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Calibration register write strobe |
| cfg_addr | input | 3 | Calibration register select (see R5) |
| cfg_wdata | input | 10 | Calibration write data |
| req_valid | input | 1 | Conversion request |
| req_raw | input | 16 | Raw ADC code; only the low 12 bits are used |
| req_sensor | input | 3 | Sensor index, 0 to 4 |
| busy | output | 1 | Scale recomputation in progress; requests are refused |
| done | output | 1 | One-cycle strobe: `result` is new |
| result | output | 32 | Signed temperature in milli-degrees Celsius |

## Verification
Results follow these latencies:

- A conversion accepted at a rising edge shows `done` and its `result` right after that edge, so they are due one cycle after the request was driven.
- A configuration write raises `busy` one cycle after it is driven.
- `busy` falls only after two full divider passes, about 70 cycles later.

The bench drives every input just after a falling edge and decides from the sampled `busy` and sensor index whether the request is due. It then compares `done`, `result` and, after writes, `busy` at the next falling edge. Only the exact moment `busy` falls is not predicted; the bench polls for it with a bound.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int DATA_W     = 32;
    localparam int RAW_BITS   = 12;
    localparam int GE_BITS    = 10;
    localparam int VTS_BITS   = 9;
    localparam int REF_BITS   = 6;
    localparam int SLOPE_BITS = 6;
    localparam int GUARD_BITS = 3;

    // numerator of the scale, pre-shifted by the guard bits
    localparam logic [DATA_W-1:0] SCALE_NUM = 32'd203450520 << GUARD_BITS;
    localparam int SLOPE_BASE = 165;
    localparam int GE_BASE    = 10000;
    localparam int VTS_BIAS   = 3350;
    localparam int REF_MULT   = 500;

    localparam logic [GE_BITS-1:0]    DEF_GE    = 10'd512;
    localparam logic [VTS_BITS-1:0]   DEF_VTS   = 9'd260;
    localparam logic [REF_BITS-1:0]   DEF_REF   = 6'd40;
    localparam logic [SLOPE_BITS-1:0] DEF_SLOPE = 6'd0;

    // register select values on the configuration port
    localparam int ADDR_GE    = 0;
    localparam int ADDR_REF   = 1;
    localparam int ADDR_SLOPE = 2;
    localparam int ADDR_VTS0  = 3;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_DIV_SLOPE,
        ST_DIV_GAIN,
        ST_READY
    } seq_state_t;

    typedef enum logic {
        DV_IDLE,
        DV_RUN
    } div_state_t;

endpackage

// File: rtl/tsc_divider.sv
module tsc_divider import tsc_pkg::*; #(
    parameter int W = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);

    div_state_t    st_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [W-1:0]  dvd_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    logic [W:0]    trial;
    logic [W:0]    trial_sub;
    logic          take;

    // one restoring step: bring down the next dividend bit
    always_comb begin
        trial     = {rem_q, quo_q[W-1]};
        take      = (trial >= {1'b0, dvs_q});
        trial_sub = trial - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DV_IDLE;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                st_q  <= DV_RUN;
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                dvd_q <= dividend;
                cnt_q <= CW'(W);
            end else if (st_q == DV_RUN) begin
                rem_q <= take ? trial_sub[W-1:0] : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    st_q   <= DV_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

    // R2
    nonzero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (divisor != '0));

    // R2
    quotient_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q}) + {{W{1'b0}}, rem_q})
                    == {{W{1'b0}}, dvd_q}) && (rem_q < dvs_q));

endmodule

// File: rtl/tsc_calib_regs.sv
module tsc_calib_regs import tsc_pkg::*; #(
    parameter int NUM_SENS = 5,
    localparam int CFG_AW = $clog2(ADDR_VTS0 + NUM_SENS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CFG_AW-1:0]     addr,
    input  logic [GE_BITS-1:0]    wdata,
    output logic [GE_BITS-1:0]    ge,
    output logic [REF_BITS-1:0]   ref_t,
    output logic [SLOPE_BITS-1:0] slope,
    output logic [VTS_BITS-1:0]   vts [NUM_SENS]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ge    <= DEF_GE;
            ref_t <= DEF_REF;
            slope <= DEF_SLOPE;
        end else if (we) begin
            if (addr == CFG_AW'(ADDR_GE))    ge    <= wdata;
            if (addr == CFG_AW'(ADDR_REF))   ref_t <= wdata[REF_BITS-1:0];
            if (addr == CFG_AW'(ADDR_SLOPE)) slope <= wdata[SLOPE_BITS-1:0];
        end
    end

    for (genvar i = 0; i < NUM_SENS; i++) begin : g_vts
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vts[i] <= DEF_VTS;
            else if (we && addr == CFG_AW'(ADDR_VTS0 + i))
                vts[i] <= wdata[VTS_BITS-1:0];
        end
    end

endmodule

// File: rtl/tsc_convert.sv
module tsc_convert import tsc_pkg::*; (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [RAW_BITS-1:0] raw,
    input  logic [VTS_BITS-1:0] vts,
    input  logic [REF_BITS-1:0] ref_t,
    input  logic [DATA_W-1:0]   scale,
    output logic                done,
    output logic [DATA_W-1:0]   result
);

    logic signed [DATA_W-1:0] diff;
    logic signed [DATA_W-1:0] prod;
    logic signed [DATA_W-1:0] shr;
    logic signed [DATA_W-1:0] base;
    logic signed [DATA_W-1:0] val;

    always_comb begin
        diff = $signed(DATA_W'(raw)) - $signed(DATA_W'(vts)) - $signed(DATA_W'(VTS_BIAS));
        prod = $signed(scale) * diff;
        shr  = prod >>> GUARD_BITS;
        base = $signed(DATA_W'(ref_t)) * $signed(DATA_W'(REF_MULT));
        val  = base - shr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= fire;
            if (fire) result <= val;
        end
    end

endmodule

// File: rtl/tsense_conv.sv
module tsense_conv import tsc_pkg::*; #(
    parameter int NUM_SENS = 5,
    parameter int RAW_IN_W = 16,
    localparam int CFG_AW = $clog2(ADDR_VTS0 + NUM_SENS),
    localparam int SEL_W  = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [GE_BITS-1:0]   cfg_wdata,
    input  logic                 req_valid,
    input  logic [RAW_IN_W-1:0]  req_raw,
    input  logic [SEL_W-1:0]     req_sensor,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    result
);

    logic [GE_BITS-1:0]    ge_q;
    logic [REF_BITS-1:0]   ref_q;
    logic [SLOPE_BITS-1:0] slope_q;
    logic [VTS_BITS-1:0]   vts_q [NUM_SENS];

    seq_state_t        st_q, st_d;
    logic              div_start, div_done;
    logic [DATA_W-1:0] div_dvd, div_dvs, div_quo;
    logic [DATA_W-1:0] scale_q;

    logic              sensor_ok, fire;
    logic [VTS_BITS-1:0] vts_sel;

    tsc_calib_regs #(.NUM_SENS(NUM_SENS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ge    (ge_q),
        .ref_t (ref_q),
        .slope (slope_q),
        .vts   (vts_q)
    );

    tsc_divider #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .done     (div_done),
        .quotient (div_quo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOAD;
        else        st_q <= st_d;
    end

    // next state; any calibration write restarts the sequence
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD:      st_d = ST_DIV_SLOPE;
            ST_DIV_SLOPE: if (div_done) st_d = ST_DIV_GAIN;
            ST_DIV_GAIN:  if (div_done) st_d = ST_READY;
            ST_READY:     st_d = ST_READY;
            default:      st_d = ST_LOAD;
        endcase
        if (cfg_we) st_d = ST_LOAD;
    end

    // state outputs
    always_comb begin
        div_start = 1'b0;
        div_dvd   = SCALE_NUM;
        div_dvs   = DATA_W'(SLOPE_BASE) + DATA_W'(slope_q);
        busy      = 1'b1;
        unique case (st_q)
            ST_LOAD:      div_start = !cfg_we;
            ST_DIV_SLOPE: begin
                div_start = div_done && !cfg_we;
                div_dvd   = div_quo;
                div_dvs   = DATA_W'(GE_BASE) + DATA_W'(ge_q);
            end
            ST_DIV_GAIN:  div_start = 1'b0;
            ST_READY:     busy = 1'b0;
            default:      busy = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scale_q <= '0;
        else if (st_q == ST_DIV_GAIN && div_done && !cfg_we)
            scale_q <= div_quo;
    end

    // request qualification and reference-code select
    assign sensor_ok = ({1'b0, req_sensor} < (SEL_W + 1)'(NUM_SENS));
    assign fire      = req_valid && !busy && sensor_ok;

    always_comb begin
        vts_sel = '0;
        for (int i = 0; i < NUM_SENS; i++)
            if (req_sensor == SEL_W'(i)) vts_sel = vts_q[i];
    end

    tsc_convert u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .raw    (req_raw[RAW_BITS-1:0]),
        .vts    (vts_sel),
        .ref_t  (ref_q),
        .scale  (scale_q),
        .done   (done),
        .result (result)
    );

    // R6
    cfg_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> busy);

    // R7
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && !busy && sensor_ok));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R11
    ready_after_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st_q) == ST_DIV_GAIN) && !$past(cfg_we));

endmodule

// File: tb/tsense_conv_bench.sv
module tsense_conv_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [9:0]  cfg_wdata;
    logic        req_valid;
    logic [15:0] req_raw;
    logic [2:0]  req_sensor;
    logic        busy;
    logic        done;
    logic [31:0] result;

    tsense_conv u_tsense_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .req_valid  (req_valid),
        .req_raw    (req_raw),
        .req_sensor (req_sensor),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural calibration model
    int m_ge, m_ref, m_slope;
    int m_vts [5];
    int last_res;

    function automatic int model_conv(int raw, int s);
        int r, sc, t;
        r  = raw & 'hFFF;
        sc = (int'(203450520) << 3) / (165 + m_slope);
        sc = sc / (10000 + m_ge);
        t  = sc * (r - m_vts[s] - 3350);
        t  = t >>> 3;
        return m_ref * 500 - t;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: predict from the inputs now driven, then compare after the edge
    task automatic step(input string tag);
        bit exp_done;
        int exp_res;
        bit wrote;
        exp_done = req_valid && !busy && (req_sensor < 3'd5);
        exp_res  = last_res;
        if (exp_done) exp_res = model_conv(int'(req_raw), int'(req_sensor));
        wrote = cfg_we;
        if (cfg_we) begin
            case (int'(cfg_addr))
                0: m_ge    = int'(cfg_wdata) & 1023;
                1: m_ref   = int'(cfg_wdata) & 63;
                2: m_slope = int'(cfg_wdata) & 63;
                default: m_vts[int'(cfg_addr) - 3] = int'(cfg_wdata) & 511;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(done == exp_done, tag, "done", longint'(done), longint'(exp_done));
        check($signed(result) == exp_res, tag, "result",
              longint'($signed(result)), longint'(exp_res));
        last_res = exp_res;
        if (wrote) check(busy == 1'b1, "R6", "busy after write", longint'(busy), 1);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        for (int k = 0; k < 200; k++) begin
            if (!busy) return;
            step(tag);
        end
        check(1'b0, "R6", "busy never fell", longint'(busy), 0);
    endtask

    task automatic put_cfg(input int a, input int d, input string tag);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(a);
        cfg_wdata = 10'(d);
        step(tag);
    endtask

    task automatic conv(input int s, input int raw, input string tag);
        req_valid  = 1'b1;
        req_sensor = 3'(s);
        req_raw    = 16'(raw);
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_ge = 512; m_ref = 40; m_slope = 0;
        for (int i = 0; i < 5; i++) m_vts[i] = 260;
        last_res   = 0;
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_addr   = '0;
        cfg_wdata  = '0;
        req_valid  = 1'b0;
        req_raw    = '0;
        req_sensor = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R7", "done in reset", longint'(done), 0);
        check(result == 32'd0, "R7", "result in reset", longint'(result), 0);
        check(busy == 1'b1, "R6", "busy in reset", longint'(busy), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R6", "busy after reset", longint'(busy), 1);
        // R8: request during the start-up recomputation
        conv(0, 'h800, "R8");
        wait_ready("R6");

        // R4 / R3: default calibration, each sensor, spread of codes
        conv(0, 'h0D0C, "R4");
        conv(1, 'h000,  "R3");
        conv(2, 'hFFF,  "R3");
        conv(3, 'h900,  "R4");
        conv(4, 'h600,  "R3");
        step("R7");

        // R1: upper raw bits are dropped
        conv(0, 'hF0D0, "R1");
        conv(0, 'h00D0, "R1");
        conv(1, 'hA123, "R1");

        // R9: out-of-range sensor index
        conv(5, 'h100, "R9");
        conv(7, 'h100, "R9");
        conv(6, 'h100, "R9");

        // R11 / R8: writes during recomputation restart it
        put_cfg(0, 1023, "R5");
        repeat (5) step("R11");
        put_cfg(2, 63, "R11");
        conv(2, 'h700, "R8");
        repeat (20) step("R11");
        put_cfg(1, 'h3C5, "R5");
        wait_ready("R11");
        conv(0, 'h500, "R2");
        conv(3, 'hC00, "R2");

        // R5: every sensor reference code, wide data truncated
        put_cfg(3, 'h3FF, "R5");
        put_cfg(4, 100, "R5");
        put_cfg(5, 0, "R5");
        put_cfg(6, 300, "R5");
        put_cfg(7, 450, "R5");
        wait_ready("R5");
        for (int s = 0; s < 5; s++) conv(s, 'hA00, "R5");
        conv(2, 'h000, "R3");
        conv(2, 'hFFF, "R3");

        // R10: write and request in the same cycle
        put_cfg(1, 63, "R5");
        wait_ready("R5");
        req_valid  = 1'b1;
        req_sensor = 3'd0;
        req_raw    = 16'h0800;
        cfg_we     = 1'b1;
        cfg_addr   = 3'd3;
        cfg_wdata  = 10'd20;
        step("R10");
        wait_ready("R10");
        conv(0, 'h0800, "R10");

        // R2: slope and gain back to small values
        put_cfg(2, 7, "R2");
        put_cfg(0, 0, "R2");
        wait_ready("R2");
        conv(4, 'h321, "R2");
        conv(1, 'hFFF, "R3");
        step("R7");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule